// File: doc/BRIEF.md
# Cache Line Lock State Manager

This block holds the per-line state of an eight-way set-associative write-through cache: a valid bit, a pending-fill bit, a lock bit with its class (instruction or data), a stale bit and a tag with one even-parity bit. Because the cache is write-through, no line is ever modified or dirty. The block decodes a 36-bit address into tag and set. It applies lock, unlock, flush and fill requests to that set and returns one registered response per request. A configuration write can lock the whole cache and can clear the lock bits of either class, or of both, in a single clock.

Requests use a valid/ready handshake. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low during reset and in the first cycle after it, and high from then on, so the block never applies back-pressure once running. The response is a one-cycle `rsp_valid` pulse that cannot be stalled. The response fields hold their value until the next response. A separate combinational readout reports the stored state of any chosen set and way.

Opcodes on `req_op`:
- 0: read
- 1: write
- 2: snooped flush
- 3: fill start
- 4: fill end
- 5: lock set
- 6: lock clear
- 7: no operation

Configuration write bits on `cfg_wdata`:
- bit 0: whole-cache lock, held as a level
- bit 1: flash-clear instruction-class locks
- bit 2: flash-clear data-class locks

Top module: `lk_state`

## Requirements
- R1: After reset every line reads back with valid, lock, class, stale, pending and tag all zero, `rsp_valid` is low and `cfg_cache_lock` is low.
- R2: The tag is `req_addr[35:16]` and the set is `req_addr[15:5]`; bits [4:0] do not affect the lookup, and a hit needs a valid line in the set whose stored tag equals the request tag.
- R3: A tag match on a line whose stored parity bit differs from the even parity of its tag gives `rsp_perr`=1 and `rsp_hit`=0 and changes no state; `req_bad_par` stores an inverted parity bit on allocation.
- R4: A lock set (opcode 5, or opcode 1 with `req_lock`) that hits sets the line's lock bit and its class (`req_iclass`, 1 = instruction). On a miss it allocates a valid, locked line in the victim way and reports that way.
- R5: A configuration write clears, in the same clock, every lock whose class bit equals 1 (bit 1) and/or 0 (bit 2); the clear wins over a lock set to the same line in that cycle.
- R6: A read with `req_unlock`, or opcode 6, that hits clears the lock bit of the hit line and leaves a miss without effect.
- R7: A snooped flush that hits invalidates the line and clears its lock, unless the whole-cache lock is set; in that case the line is unchanged.
- R8: A lock-set or fill-start miss with no eligible way sets `rsp_ovf` and allocates nothing; with the whole-cache lock set, no way is eligible.
- R9: A flush that matches a line with a fill pending clears pending and lock and sets stale; a later fill end for that tag finds nothing.
- R10: The victim is the lowest-numbered way that is invalid, not pending and unlocked; if there is none, it is the lowest-numbered way that is unlocked and not pending.
- R11: A fill-start miss allocates the victim as pending (not valid); a fill end that matches a pending line makes it valid and reports a hit.
- R12: `req_ready` goes high in the second cycle after reset, and each accepted request produces `rsp_valid` in the next cycle.
- R13: `rd_lock_eff` is the line's lock bit ORed with the whole-cache lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken |
| req_op | input | 3 | Opcode |
| req_addr | input | 36 | Byte address |
| req_lock | input | 1 | Lock attribute on a write |
| req_unlock | input | 1 | Unlock attribute on a read |
| req_iclass | input | 1 | Lock class: 1 instruction, 0 data |
| req_bad_par | input | 1 | Store inverted tag parity on allocation |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | Whole-cache lock, instruction flash clear, data flash clear |
| cfg_cache_lock | output | 1 | Current whole-cache lock |
| rd_set | input | 11 | Readout set |
| rd_way | input | 3 | Readout way |
| rd_valid | output | 1 | Line valid |
| rd_lock | output | 1 | Line lock bit |
| rd_iclass | output | 1 | Line lock class |
| rd_stale | output | 1 | Line stale |
| rd_pend | output | 1 | Fill pending |
| rd_tag | output | 20 | Stored tag |
| rd_lock_eff | output | 1 | Effective lock |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Request hit |
| rsp_way | output | 3 | Hit or allocated way |
| rsp_perr | output | 1 | Tag parity error |
| rsp_ovf | output | 1 | No way could be allocated |

## Verification
The assertions watch, on every cycle, properties that hold in any state:
- a parity error or an overflow never comes with a hit;
- at most one way hits;
- a stale or pending line is never valid;
- each accepted request brings a response;
- a two-class flash clear leaves no lock standing;
- a flush under the whole-cache lock does not drop the line being read out.

Victim order, lock classes, the priority of a flash clear over a same-cycle lock set, and the stale path of a fill cut by a snoop depend on earlier history. Only the bench scenarios can show these, checked against a bench model of every line.

// File: rtl/lk_pkg.sv
package lk_pkg;
  typedef enum logic [2:0] {
    OP_READ     = 3'd0,
    OP_WRITE    = 3'd1,
    OP_FLUSH    = 3'd2,
    OP_FILL_GO  = 3'd3,
    OP_FILL_END = 3'd4,
    OP_LOCK     = 3'd5,
    OP_UNLOCK   = 3'd6,
    OP_NOP      = 3'd7
  } lk_op_e;
endpackage

// File: rtl/lk_addr_split.sv
module lk_addr_split #(
  parameter int ADDR_W = 36,
  parameter int OFS_W  = 5,
  parameter int SET_W  = 11,
  parameter int TAG_W  = ADDR_W - SET_W - OFS_W
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [SET_W-1:0]  set_idx,
  output logic [TAG_W-1:0]  tag,
  output logic [OFS_W-1:0]  ofs
);
  assign ofs     = addr[OFS_W-1:0];
  assign set_idx = addr[OFS_W +: SET_W];
  assign tag     = addr[ADDR_W-1 -: TAG_W];
endmodule

// File: rtl/lk_tag_match.sv
module lk_tag_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 20
) (
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [WAYS-1:0]       par,
  input  logic [WAYS-1:0]       valid,
  input  logic [WAYS-1:0]       pend,
  input  logic [TAG_W-1:0]      look_tag,
  output logic [WAYS-1:0]       hit_vec,
  output logic [WAYS-1:0]       pend_vec,
  output logic [WAYS-1:0]       perr_vec
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic eq, ok;
    assign eq          = (tags[w*TAG_W +: TAG_W] == look_tag);
    assign ok          = ((^tags[w*TAG_W +: TAG_W]) == par[w]);
    assign hit_vec[w]  = valid[w] & eq & ok;
    assign pend_vec[w] = pend[w] & eq & ok;
    assign perr_vec[w] = (valid[w] | pend[w]) & eq & ~ok;
  end
endmodule

// File: rtl/lk_victim.sv
module lk_victim #(
  parameter int WAYS  = 8,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid,
  input  logic [WAYS-1:0]  lock,
  input  logic [WAYS-1:0]  pend,
  input  logic             all_lock,
  output logic             found,
  output logic [WAY_W-1:0] way
);
  logic [WAYS-1:0] free, pref, pick;

  assign free = ~lock & ~pend & {WAYS{~all_lock}};
  assign pref = free & ~valid;
  assign pick = (|pref) ? pref : free;

  always_comb begin
    found = |pick;
    way   = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (pick[w]) way = WAY_W'(w);
    end
  end
endmodule

// File: rtl/lk_state.sv
module lk_state #(
  parameter int ADDR_W = 36,
  parameter int LINE_B = 32,
  parameter int SETS   = 2048,
  parameter int WAYS   = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [2:0]                req_op,
  input  logic [ADDR_W-1:0]         req_addr,
  input  logic                      req_lock,
  input  logic                      req_unlock,
  input  logic                      req_iclass,
  input  logic                      req_bad_par,
  input  logic                      cfg_we,
  input  logic [2:0]                cfg_wdata,
  output logic                      cfg_cache_lock,
  input  logic [$clog2(SETS)-1:0]   rd_set,
  input  logic [$clog2(WAYS)-1:0]   rd_way,
  output logic                      rd_valid,
  output logic                      rd_lock,
  output logic                      rd_iclass,
  output logic                      rd_stale,
  output logic                      rd_pend,
  output logic [ADDR_W-$clog2(SETS)-$clog2(LINE_B)-1:0] rd_tag,
  output logic                      rd_lock_eff,
  output logic                      rsp_valid,
  output logic                      rsp_hit,
  output logic [$clog2(WAYS)-1:0]   rsp_way,
  output logic                      rsp_perr,
  output logic                      rsp_ovf
);
  import lk_pkg::*;

  localparam int OFS_W = $clog2(LINE_B);
  localparam int SET_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int TAG_W = ADDR_W - SET_W - OFS_W;

  // line state, one word of WAYS bits per set
  logic [WAYS-1:0]       v_q  [SETS];
  logic [WAYS-1:0]       l_q  [SETS];
  logic [WAYS-1:0]       ic_q [SETS];
  logic [WAYS-1:0]       st_q [SETS];
  logic [WAYS-1:0]       pd_q [SETS];
  logic [WAYS-1:0]       pr_q [SETS];
  logic [WAYS*TAG_W-1:0] tg_q [SETS];
  logic                  all_lock_q, ready_q;

  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] req_tag;
  logic [OFS_W-1:0] req_ofs;
  lk_op_e           op;
  logic             fire;

  assign op        = lk_op_e'(req_op);
  assign req_ready = ready_q;
  assign fire      = req_valid & ready_q;

  lk_addr_split #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .SET_W(SET_W), .TAG_W(TAG_W)) u_split (
    .addr(req_addr), .set_idx(set_idx), .tag(req_tag), .ofs(req_ofs)
  );

  logic [WAYS-1:0] hit_vec, pend_vec, perr_vec;
  lk_tag_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags(tg_q[set_idx]), .par(pr_q[set_idx]), .valid(v_q[set_idx]),
    .pend(pd_q[set_idx]), .look_tag(req_tag),
    .hit_vec(hit_vec), .pend_vec(pend_vec), .perr_vec(perr_vec)
  );

  logic             vic_found;
  logic [WAY_W-1:0] vic_way;
  lk_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) u_victim (
    .valid(v_q[set_idx]), .lock(l_q[set_idx]), .pend(pd_q[set_idx]),
    .all_lock(all_lock_q), .found(vic_found), .way(vic_way)
  );

  logic [WAY_W-1:0] hway, pway;
  always_comb begin
    hway = '0;
    pway = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w])  hway = WAY_W'(w);
      if (pend_vec[w]) pway = WAY_W'(w);
    end
  end

  // next state of the addressed set and the response
  logic [WAYS-1:0]       n_v, n_l, n_ic, n_st, n_pd, n_pr;
  logic [WAYS*TAG_W-1:0] n_tg;
  logic                  o_hit, o_perr, o_ovf;
  logic [WAY_W-1:0]      o_way;
  logic                  hit_any, pm_any;

  assign hit_any = |hit_vec;
  assign pm_any  = |pend_vec;

  always_comb begin
    n_v  = v_q[set_idx];
    n_l  = l_q[set_idx];
    n_ic = ic_q[set_idx];
    n_st = st_q[set_idx];
    n_pd = pd_q[set_idx];
    n_pr = pr_q[set_idx];
    n_tg = tg_q[set_idx];
    o_hit = 1'b0; o_perr = 1'b0; o_ovf = 1'b0; o_way = '0;
    if (|perr_vec) begin
      o_perr = 1'b1;
    end else begin
      case (op)
        OP_READ, OP_UNLOCK: begin
          o_hit = hit_any;
          o_way = hway;
          if (hit_any && (op == OP_UNLOCK || req_unlock)) n_l[hway] = 1'b0;
        end
        OP_WRITE, OP_LOCK: begin
          o_hit = hit_any;
          o_way = hway;
          if (op == OP_LOCK || req_lock) begin
            if (hit_any) begin
              n_l[hway]  = 1'b1;
              n_ic[hway] = req_iclass;
            end else if (!pm_any) begin
              if (vic_found) begin
                o_way = vic_way;
                n_v[vic_way]  = 1'b1;
                n_l[vic_way]  = 1'b1;
                n_ic[vic_way] = req_iclass;
                n_st[vic_way] = 1'b0;
                n_pd[vic_way] = 1'b0;
                n_pr[vic_way] = (^req_tag) ^ req_bad_par;
                n_tg[vic_way*TAG_W +: TAG_W] = req_tag;
              end else begin
                o_ovf = 1'b1;
              end
            end
          end
        end
        OP_FLUSH: begin
          o_hit = hit_any;
          o_way = hway;
          if (!all_lock_q) begin
            if (hit_any) begin
              n_v[hway] = 1'b0;
              n_l[hway] = 1'b0;
            end else if (pm_any) begin
              n_pd[pway] = 1'b0;
              n_st[pway] = 1'b1;
              n_l[pway]  = 1'b0;
            end
          end
        end
        OP_FILL_GO: begin
          o_hit = hit_any;
          o_way = hway;
          if (!hit_any && !pm_any) begin
            if (vic_found) begin
              o_way = vic_way;
              n_v[vic_way]  = 1'b0;
              n_l[vic_way]  = 1'b0;
              n_ic[vic_way] = req_iclass;
              n_st[vic_way] = 1'b0;
              n_pd[vic_way] = 1'b1;
              n_pr[vic_way] = (^req_tag) ^ req_bad_par;
              n_tg[vic_way*TAG_W +: TAG_W] = req_tag;
            end else begin
              o_ovf = 1'b1;
            end
          end
        end
        OP_FILL_END: begin
          o_hit = pm_any;
          o_way = pway;
          if (pm_any) begin
            n_v[pway]  = 1'b1;
            n_pd[pway] = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  logic fl_i, fl_d;
  assign fl_i = cfg_we & cfg_wdata[1];
  assign fl_d = cfg_we & cfg_wdata[2];

  function automatic logic [WAYS-1:0] clr_mask(input logic [WAYS-1:0] ic,
                                               input logic fi, input logic fd);
    return ({WAYS{fi}} & ic) | ({WAYS{fd}} & ~ic);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        v_q[s] <= '0; l_q[s] <= '0; ic_q[s] <= '0; st_q[s] <= '0;
        pd_q[s] <= '0; pr_q[s] <= '0; tg_q[s] <= '0;
      end
      all_lock_q <= 1'b0;
      ready_q    <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_way    <= '0;
      rsp_perr   <= 1'b0;
      rsp_ovf    <= 1'b0;
    end else begin
      ready_q   <= 1'b1;
      rsp_valid <= fire;
      if (cfg_we) all_lock_q <= cfg_wdata[0];
      if (fl_i || fl_d) begin
        for (int s = 0; s < SETS; s++) l_q[s] <= l_q[s] & ~clr_mask(ic_q[s], fl_i, fl_d);
      end
      if (fire) begin
        v_q[set_idx]  <= n_v;
        l_q[set_idx]  <= n_l & ~clr_mask(n_ic, fl_i, fl_d);
        ic_q[set_idx] <= n_ic;
        st_q[set_idx] <= n_st;
        pd_q[set_idx] <= n_pd;
        pr_q[set_idx] <= n_pr;
        tg_q[set_idx] <= n_tg;
        rsp_hit  <= o_hit;
        rsp_way  <= o_way;
        rsp_perr <= o_perr;
        rsp_ovf  <= o_ovf;
      end
    end
  end

  assign cfg_cache_lock = all_lock_q;
  assign rd_valid    = v_q[rd_set][rd_way];
  assign rd_lock     = l_q[rd_set][rd_way];
  assign rd_iclass   = ic_q[rd_set][rd_way];
  assign rd_stale    = st_q[rd_set][rd_way];
  assign rd_pend     = pd_q[rd_set][rd_way];
  assign rd_tag      = tg_q[rd_set][rd_way*TAG_W +: TAG_W];
  assign rd_lock_eff = rd_lock | all_lock_q;

  // assertions
  a_r3_perr_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_perr) |-> !rsp_hit);
  a_r8_ovf_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_ovf) |-> !rsp_hit);
  a_r2_one_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  a_r9_stale_invalid: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stale || rd_pend) |-> !rd_valid);
  a_r12_resp: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);
  a_r5_flash_both: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_wdata[1] && cfg_wdata[2]) |=> !rd_lock);
  a_r7_locked_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && op == OP_FLUSH && all_lock_q && rd_valid && rd_set == set_idx
     && rd_tag == req_tag && req_ofs == req_ofs)
    |=> (!$stable(rd_set) || !$stable(rd_way) || rd_valid));
endmodule

// File: tb/test_lk_state.sv
`timescale 1ns/1ps
module test_lk_state;
  localparam int NS = 2048;
  localparam int NW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_ready;
  logic [2:0]  req_op = 0;
  logic [35:0] req_addr = 0;
  logic        req_lock = 0, req_unlock = 0, req_iclass = 0, req_bad_par = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_wdata = 0;
  logic        cfg_cache_lock;
  logic [10:0] rd_set = 0;
  logic [2:0]  rd_way = 0;
  logic        rd_valid, rd_lock, rd_iclass, rd_stale, rd_pend, rd_lock_eff;
  logic [19:0] rd_tag;
  logic        rsp_valid, rsp_hit, rsp_perr, rsp_ovf;
  logic [2:0]  rsp_way;

  lk_state i_lk_state (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_lock(req_lock), .req_unlock(req_unlock),
    .req_iclass(req_iclass), .req_bad_par(req_bad_par), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_cache_lock(cfg_cache_lock), .rd_set(rd_set),
    .rd_way(rd_way), .rd_valid(rd_valid), .rd_lock(rd_lock), .rd_iclass(rd_iclass),
    .rd_stale(rd_stale), .rd_pend(rd_pend), .rd_tag(rd_tag), .rd_lock_eff(rd_lock_eff),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_perr(rsp_perr), .rsp_ovf(rsp_ovf)
  );

  int total = 0;
  int bad = 0;

  // bench model of every line
  bit        mv [NS][NW];
  bit        ml [NS][NW];
  bit        mic[NS][NW];
  bit        mst[NS][NW];
  bit        mpd[NS][NW];
  bit        mbp[NS][NW];
  bit [19:0] mtg[NS][NW];
  bit        mcl;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit [35:0] mk(input int s, input int t, input int o);
    return {20'(t), 11'(s), 5'(o)};
  endfunction

  task automatic check_line(input int s, input int w, input string req);
    rd_set = 11'(s);
    rd_way = 3'(w);
    #1;
    chk({rd_valid, rd_lock, rd_iclass, rd_stale, rd_pend, rd_tag, rd_lock_eff} ==
        {mv[s][w], ml[s][w], mic[s][w], mst[s][w], mpd[s][w], mtg[s][w], ml[s][w] | mcl},
        req, "line readout",
        {38'd0, rd_valid, rd_lock, rd_iclass, rd_stale, rd_pend, rd_tag, rd_lock_eff},
        {38'd0, mv[s][w], ml[s][w], mic[s][w], mst[s][w], mpd[s][w], mtg[s][w], ml[s][w] | mcl});
  endtask

  task automatic alloc(input int s, input int w, input bit [19:0] t, input bit valid,
                       input bit lk, input bit ic, input bit bp);
    mv[s][w] = valid; mpd[s][w] = !valid; ml[s][w] = lk; mic[s][w] = ic;
    mst[s][w] = 0; mtg[s][w] = t; mbp[s][w] = bp;
  endtask

  // one request, checked against the model; tw returns the touched way or -1
  task automatic step(input int op, input bit [35:0] a, input bit lk, input bit ul,
                      input bit ic, input bit bp, input bit cw, input bit [2:0] cd,
                      output int tw);
    int s = int'(a[15:5]);
    bit [19:0] t = a[35:16];
    int hw = -1, pw = -1, vw = -1, ew = -1;
    bit pe = 0, eh = 0, eo = 0;
    string rq = "R4";
    tw = -1;
    for (int w = 0; w < NW; w++)
      if ((mv[s][w] || mpd[s][w]) && mtg[s][w] == t) begin
        if (mbp[s][w]) pe = 1;
        else begin
          if (mv[s][w]) hw = w;
          if (mpd[s][w]) pw = w;
        end
      end
    for (int w = 0; w < NW; w++)
      if (vw < 0 && !mcl && !ml[s][w] && !mpd[s][w] && !mv[s][w]) vw = w;
    for (int w = 0; w < NW; w++)
      if (vw < 0 && !mcl && !ml[s][w] && !mpd[s][w]) vw = w;
    if (pe) rq = "R3";
    else begin
      case (op)
        0, 6: begin
          rq = "R6"; eh = hw >= 0; ew = hw;
          if (hw >= 0 && (op == 6 || ul)) begin ml[s][hw] = 0; tw = hw; end
        end
        1, 5: begin
          eh = hw >= 0; ew = hw;
          if (op == 5 || lk) begin
            if (hw >= 0) begin ml[s][hw] = 1; mic[s][hw] = ic; tw = hw; end
            else if (pw < 0) begin
              if (vw >= 0) begin alloc(s, vw, t, 1, 1, ic, bp); ew = vw; tw = vw; rq = "R10"; end
              else begin eo = 1; rq = "R8"; end
            end
          end
        end
        2: begin
          rq = "R7"; eh = hw >= 0; ew = hw;
          if (hw >= 0) tw = hw;
          if (!mcl) begin
            if (hw >= 0) begin mv[s][hw] = 0; ml[s][hw] = 0; end
            else if (pw >= 0) begin mpd[s][pw] = 0; mst[s][pw] = 1; ml[s][pw] = 0; tw = pw; rq = "R9"; end
          end
        end
        3: begin
          rq = "R11"; eh = hw >= 0; ew = hw;
          if (hw < 0 && pw < 0) begin
            if (vw >= 0) begin alloc(s, vw, t, 0, 0, ic, bp); ew = vw; tw = vw; end
            else begin eo = 1; rq = "R8"; end
          end
        end
        4: begin
          rq = "R11"; eh = pw >= 0; ew = pw;
          if (pw >= 0) begin mv[s][pw] = 1; mpd[s][pw] = 0; tw = pw; end
        end
        default: ;
      endcase
    end
    @(negedge clk);
    req_valid = 1; req_op = 3'(op); req_addr = a; req_lock = lk; req_unlock = ul;
    req_iclass = ic; req_bad_par = bp; cfg_we = cw; cfg_wdata = cd;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    if (cw) begin
      for (int x = 0; x < NS; x++)
        for (int w = 0; w < NW; w++)
          if ((cd[1] && mic[x][w]) || (cd[2] && !mic[x][w])) ml[x][w] = 0;
      mcl = cd[0];
    end
    chk(rsp_valid && rsp_hit == eh && rsp_perr == pe && rsp_ovf == eo &&
        (ew < 0 || int'(rsp_way) == ew), rq, "response",
        {58'd0, rsp_valid, rsp_hit, rsp_perr, rsp_ovf, rsp_way[1:0]},
        {58'd0, 1'b1, eh, pe, eo, 2'(ew)});
    check_line(s, (tw >= 0) ? tw : int'($urandom_range(0, NW - 1)), "R13");
  endtask

  initial begin
    #1_000_000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int tw;
    void'($urandom(32'd77));
    mcl = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    // R1 reset state
    chk(rsp_valid == 0 && cfg_cache_lock == 0, "R1", "reset outputs",
        {62'd0, rsp_valid, cfg_cache_lock}, 64'd0);
    check_line(0, 0, "R1");
    check_line(2047, 7, "R1");
    check_line(700, 3, "R1");
    @(negedge clk);
    chk(req_ready == 1, "R12", "ready after reset", {63'd0, req_ready}, 64'd1);

    // R10 fill the set in way order, then R8 overflow
    for (int i = 0; i < 8; i++) begin
      step(5, mk(7, 100 + i, 0), 0, 0, i[0], 0, 0, 0, tw);
      chk(tw == i, "R10", "victim order", 64'(tw), 64'(i));
    end
    step(5, mk(7, 120, 0), 0, 0, 0, 0, 0, 0, tw);
    chk(rsp_ovf == 1, "R8", "all ways locked", {63'd0, rsp_ovf}, 64'd1);

    // R6 unlock by read attribute, then the freed way is the victim
    step(0, mk(7, 103, 9), 0, 1, 0, 0, 0, 0, tw);
    step(0, mk(7, 104, 9), 0, 0, 0, 0, 0, 0, tw);
    check_line(7, 4, "R6");
    chk(rd_lock == 1, "R6", "plain read keeps lock", {63'd0, rd_lock}, 64'd1);
    step(1, mk(7, 200, 0), 1, 0, 0, 0, 0, 0, tw);
    chk(tw == 3, "R10", "unlocked way reused", 64'(tw), 64'd3);

    // R5 data flash clear wins over same-cycle lock set
    step(5, mk(7, 200, 0), 0, 0, 0, 0, 1, 3'b100, tw);
    check_line(7, 3, "R5");
    chk(rd_lock == 0, "R5", "flash beats lock set", {63'd0, rd_lock}, 64'd0);
    check_line(7, 1, "R5");
    chk(rd_lock == 1, "R5", "instruction lock kept", {63'd0, rd_lock}, 64'd1);

    // R7/R8/R13 whole-cache lock
    step(7, 0, 0, 0, 0, 0, 1, 3'b001, tw);
    check_line(7, 0, "R13");
    chk(rd_lock_eff == 1 && cfg_cache_lock == 1, "R13", "effective lock",
        {62'd0, rd_lock_eff, cfg_cache_lock}, 64'd3);
    step(2, mk(7, 100, 0), 0, 0, 0, 0, 0, 0, tw);
    check_line(7, 0, "R7");
    chk(rd_valid == 1, "R7", "flush blocked", {63'd0, rd_valid}, 64'd1);
    step(5, mk(7, 300, 0), 0, 0, 0, 0, 0, 0, tw);
    chk(rsp_ovf == 1, "R8", "cache lock blocks alloc", {63'd0, rsp_ovf}, 64'd1);
    step(7, 0, 0, 0, 0, 0, 1, 3'b000, tw);
    step(2, mk(7, 100, 0), 0, 0, 0, 0, 0, 0, tw);
    check_line(7, 0, "R7");
    chk(rd_valid == 0, "R7", "flush invalidates", {63'd0, rd_valid}, 64'd0);

    // R9 snoop during pending fill, R11 normal fill
    step(3, mk(9, 5, 0), 0, 0, 0, 0, 0, 0, tw);
    step(2, mk(9, 5, 0), 0, 0, 0, 0, 0, 0, tw);
    check_line(9, 0, "R9");
    chk(rd_stale == 1 && rd_pend == 0, "R9", "stale set", {62'd0, rd_stale, rd_pend}, 64'd2);
    step(4, mk(9, 5, 0), 0, 0, 0, 0, 0, 0, tw);
    chk(rsp_hit == 0, "R9", "fill end finds nothing", {63'd0, rsp_hit}, 64'd0);
    step(3, mk(9, 6, 0), 0, 0, 0, 0, 0, 0, tw);
    step(4, mk(9, 6, 0), 0, 0, 0, 0, 0, 0, tw);
    chk(rsp_hit == 1, "R11", "fill end hits", {63'd0, rsp_hit}, 64'd1);

    // R3 parity and R2 address fields
    step(5, mk(9, 7, 0), 0, 0, 0, 1, 0, 0, tw);
    step(0, mk(9, 7, 0), 0, 0, 0, 0, 0, 0, tw);
    chk(rsp_perr == 1 && rsp_hit == 0, "R3", "parity error", {62'd0, rsp_perr, rsp_hit}, 64'd2);
    step(0, mk(9, 6, 31), 0, 0, 0, 0, 0, 0, tw);
    chk(rsp_hit == 1, "R2", "offset ignored", {63'd0, rsp_hit}, 64'd1);
    step(0, mk(10, 6, 0), 0, 0, 0, 0, 0, 0, tw);
    chk(rsp_hit == 0, "R2", "other set misses", {63'd0, rsp_hit}, 64'd0);

    // random mix on two sets
    for (int n = 0; n < 3000; n++) begin
      int s = ($urandom_range(0, 1) == 0) ? 5 : 1234;
      bit cw = ($urandom_range(0, 39) == 0);
      bit [2:0] cd = {1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      1'($urandom_range(0, 3) == 0)};
      step(int'($urandom_range(0, 6)), mk(s, int'($urandom_range(0, 11)), int'($urandom_range(0, 31))),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
           ($urandom_range(0, 19) == 0), cw, cd, tw);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule